// File: doc/BRIEF.md
# I2C Serial Clock Timing Generator

This block derives the serial clock of an I2C master from a faster functional clock. A programmable prescaler first divides the functional clock by `psc + 1` to produce a tick. Two programmable counts then set how many ticks the clock stays low and how many it stays high. Each count carries a fixed extra amount on top of the programmed field: 7 ticks for the low phase and 5 ticks for the high phase. The bus rate is therefore fclk / ((psc + 1) × (low + 7 + high + 5)). For example, with a 48 MHz functional clock and psc = 1, the field pairs 111/117, 23/25 and 5/7 give 100 kHz, 400 kHz and 1 MHz.

A period always starts with its low phase. The block produces the SCL drive level and four single-cycle strobes:
- a falling-edge strobe;
- a rising-edge strobe;
- a strobe at the centre of the high phase, where SDA is sampled;
- a strobe at the centre of the low phase, where SDA may be changed.

The settings are captured only when a period begins, so a write never produces a shortened or stretched phase. Driving data on SDA is left to the surrounding master logic.

Top module: `i2c_scl_gen`

## Requirements
- R1: While `en_i` is low, `scl_o` is 1 and all four strobes are 0. Dropping `en_i` at any point releases SCL high on the next cycle, and counting restarts from scratch on the next enable.
- R2: On the first clock edge that samples `en_i` high, `scl_o` goes to 0 and `fall_o` pulses. This starts the first period with a low phase.
- R3: The low phase lasts (`low_cnt_i[7:0]` + 7) × (`psc_i` + 1) functional clock cycles.
- R4: The high phase lasts (`high_cnt_i[7:0]` + 5) × (`psc_i` + 1) functional clock cycles.
- R5: One full period lasts (`psc_i` + 1) × (`low_cnt_i[7:0]` + `high_cnt_i[7:0]` + 12) cycles.
- R6: Bits [15:8] of `low_cnt_i` and `high_cnt_i` have no effect on the timing.
- R7: `psc_i`, `low_cnt_i` and `high_cnt_i` are captured only on the edge that starts a period: either the enabling edge or the edge that ends a high phase. A value present at that edge governs the whole new period, and changes at any other time do not affect the period in progress.
- R8: `rise_o` and `fall_o` each pulse for exactly one cycle, in the cycle in which `scl_o` has just changed to 1 or to 0. At most one strobe is active in any cycle.
- R9: `sample_o` pulses once per high phase, floor((`high_cnt_i[7:0]` + 5) / 2) × (`psc_i` + 1) cycles after `rise_o`.
- R10: `change_o` pulses once per low phase, floor((`low_cnt_i[7:0]` + 7) / 2) × (`psc_i` + 1) cycles after `fall_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run the generator; when low, SCL is released and all counters are cleared |
| psc_i | input | 8 | Prescale field; divides the clock by psc_i + 1 |
| low_cnt_i | input | 16 | Low-phase count; bits [7:0] used |
| high_cnt_i | input | 16 | High-phase count; bits [7:0] used |
| scl_o | output | 1 | SCL drive level (1 = released) |
| rise_o | output | 1 | Single-cycle strobe when SCL rises |
| fall_o | output | 1 | Single-cycle strobe when SCL falls |
| sample_o | output | 1 | Single-cycle strobe at the centre of the high phase |
| change_o | output | 1 | Single-cycle strobe at the centre of the low phase |

## Verification
The critical coincidence is a configuration write that lands on the same edge that ends a high phase and starts the next period. On that edge the old high phase must finish at its full old length, and the new low phase must already use the new values.

The bench provokes this by waiting for `rise_o` and counting off one cycle less than the known high length. It then drives new settings just before the terminating edge and measures the following low phase and high phase against the new values. A companion scenario changes the settings in the middle of a low phase and checks that the running period keeps its old lengths.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;
  localparam int unsigned LOW_EXTRA  = 7;
  localparam int unsigned HIGH_EXTRA = 5;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } scl_phase_e;
endpackage

// File: rtl/scl_cfg_latch.sv
module scl_cfg_latch
  import i2c_scl_pkg::*;
#(
  parameter int unsigned REG_W   = 16,
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned CNT_W   = FIELD_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FIELD_W-1:0] psc_i,
  input  logic [REG_W-1:0]   low_i,
  input  logic [REG_W-1:0]   high_i,
  output logic [FIELD_W-1:0] psc_o,
  output logic [CNT_W-1:0]   low_len_o,
  output logic [CNT_W-1:0]   high_len_o
);
  logic [FIELD_W-1:0] psc_q;
  logic [CNT_W-1:0]   low_len_q, high_len_q;

  // upper register bits carry no timing meaning here
  logic unused_upper;
  assign unused_upper = ^{low_i[REG_W-1:FIELD_W], high_i[REG_W-1:FIELD_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q      <= '0;
      low_len_q  <= CNT_W'(LOW_EXTRA);
      high_len_q <= CNT_W'(HIGH_EXTRA);
    end else if (load_i) begin
      psc_q      <= psc_i;
      low_len_q  <= CNT_W'(low_i[FIELD_W-1:0]) + CNT_W'(LOW_EXTRA);
      high_len_q <= CNT_W'(high_i[FIELD_W-1:0]) + CNT_W'(HIGH_EXTRA);
    end
  end

  assign psc_o      = psc_q;
  assign low_len_o  = low_len_q;
  assign high_len_o = high_len_q;

  assert_len_floor_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_len_o >= CNT_W'(LOW_EXTRA)) && (high_len_o >= CNT_W'(HIGH_EXTRA)));
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int unsigned FIELD_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [FIELD_W-1:0] psc_i,
  output logic               tick_o
);
  logic [FIELD_W-1:0] pc_q;

  assign tick_o = run_i && (pc_q == psc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pc_q <= '0;
    else if (!run_i || tick_o)  pc_q <= '0;
    else                        pc_q <= pc_q + 1'b1;
  end

  // settings only change when the count has just restarted
  assert_pc_in_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (pc_q <= psc_i));

  assert_idle_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (pc_q == '0));
endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
  import i2c_scl_pkg::*;
#(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] low_len_i,
  input  logic [CNT_W-1:0] high_len_i,
  output logic             run_o,
  output logic             load_o,
  output logic             scl_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic             sample_o,
  output logic             change_o
);
  scl_phase_e       phase_q;
  logic             run_q, scl_q;
  logic             rise_q, fall_q, sample_q, change_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt, cur_len;
  logic             start, last;

  assign cur_len = (phase_q == PH_HIGH) ? high_len_i : low_len_i;
  assign cnt_nxt = cnt_q + 1'b1;
  assign start   = en_i && !run_q;
  assign last    = tick_i && (cnt_q == cur_len - CNT_W'(1));
  assign load_o  = start || (last && phase_q == PH_HIGH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0; phase_q <= PH_LOW; cnt_q <= '0; scl_q <= 1'b1;
      rise_q <= 1'b0; fall_q <= 1'b0; sample_q <= 1'b0; change_q <= 1'b0;
    end else if (!en_i) begin
      run_q <= 1'b0; phase_q <= PH_LOW; cnt_q <= '0; scl_q <= 1'b1;
      rise_q <= 1'b0; fall_q <= 1'b0; sample_q <= 1'b0; change_q <= 1'b0;
    end else begin
      rise_q <= 1'b0; fall_q <= 1'b0; sample_q <= 1'b0; change_q <= 1'b0;
      if (start) begin
        run_q   <= 1'b1;
        phase_q <= PH_LOW;
        cnt_q   <= '0;
        scl_q   <= 1'b0;
        fall_q  <= 1'b1;
      end else if (tick_i) begin
        if (last) begin
          cnt_q <= '0;
          if (phase_q == PH_LOW) begin
            phase_q <= PH_HIGH; scl_q <= 1'b1; rise_q <= 1'b1;
          end else begin
            phase_q <= PH_LOW;  scl_q <= 1'b0; fall_q <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_nxt;
          if (phase_q == PH_HIGH && cnt_nxt == (high_len_i >> 1)) sample_q <= 1'b1;
          if (phase_q == PH_LOW  && cnt_nxt == (low_len_i  >> 1)) change_q <= 1'b1;
        end
      end
    end
  end

  assign run_o    = run_q;
  assign scl_o    = scl_q;
  assign rise_o   = rise_q;
  assign fall_o   = fall_q;
  assign sample_o = sample_q;
  assign change_o = change_q;

  assert_cnt_below_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q < cur_len));

  assert_release_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (scl_o && !rise_o && !fall_o && !sample_o && !change_o));

  assert_rise_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> (scl_o && !$past(scl_o)));

  assert_fall_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> (!scl_o && $past(scl_o)));

  assert_strobe_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise_o, fall_o, sample_o, change_o}));

  assert_sample_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> scl_o);

  assert_change_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    change_o |-> !scl_o);
endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen #(
  parameter int unsigned REG_W   = 16,
  parameter int unsigned FIELD_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [FIELD_W-1:0] psc_i,
  input  logic [REG_W-1:0]   low_cnt_i,
  input  logic [REG_W-1:0]   high_cnt_i,
  output logic               scl_o,
  output logic               rise_o,
  output logic               fall_o,
  output logic               sample_o,
  output logic               change_o
);
  localparam int unsigned CNT_W = FIELD_W + 1;

  logic               run, load, tick;
  logic [FIELD_W-1:0] psc_l;
  logic [CNT_W-1:0]   low_len, high_len;

  scl_cfg_latch #(.REG_W(REG_W), .FIELD_W(FIELD_W), .CNT_W(CNT_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .psc_i      (psc_i),
    .low_i      (low_cnt_i),
    .high_i     (high_cnt_i),
    .psc_o      (psc_l),
    .low_len_o  (low_len),
    .high_len_o (high_len)
  );

  scl_prescaler #(.FIELD_W(FIELD_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .psc_i  (psc_l),
    .tick_o (tick)
  );

  scl_phase_timer #(.CNT_W(CNT_W)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .tick_i     (tick),
    .low_len_i  (low_len),
    .high_len_i (high_len),
    .run_o      (run),
    .load_o     (load),
    .scl_o      (scl_o),
    .rise_o     (rise_o),
    .fall_o     (fall_o),
    .sample_o   (sample_o),
    .change_o   (change_o)
  );

  assert_start_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !run) |=> (fall_o && !scl_o));
endmodule

// File: tb/i2c_scl_gen_tb_top.sv
`timescale 1ns/1ps
module i2c_scl_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [7:0]  psc_i = '0;
  logic [15:0] low_cnt_i = '0;
  logic [15:0] high_cnt_i = '0;
  logic        scl_o, rise_o, fall_o, sample_o, change_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  i2c_scl_gen dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .psc_i(psc_i),
    .low_cnt_i(low_cnt_i), .high_cnt_i(high_cnt_i), .scl_o(scl_o),
    .rise_o(rise_o), .fall_o(fall_o), .sample_o(sample_o), .change_o(change_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [7:0] p, input logic [15:0] l, input logic [15:0] h);
    psc_i = p; low_cnt_i = l; high_cnt_i = h;
  endtask

  // waits for the next fall strobe and measures one period from it
  task automatic measure(input bit apply, input logic [7:0] np, input logic [15:0] nl,
                         input logic [15:0] nh, output int lo, output int hi,
                         output int smp, output int chg);
    int t;
    do @(negedge clk_i); while (!fall_o);
    t = 0; lo = -1; hi = -1; smp = -1; chg = -1;
    while (1) begin
      @(negedge clk_i);
      t++;
      if (apply && t == 3) set_cfg(np, nl, nh);
      if (change_o) chg = t;
      if (rise_o) lo = t;
      if (sample_o) smp = t - lo;
      if (fall_o) begin hi = t - lo; break; end
    end
  endtask

  task automatic restart(input logic [7:0] p, input logic [15:0] l, input logic [15:0] h);
    @(negedge clk_i); en_i = 1'b0;
    set_cfg(p, l, h);
    @(negedge clk_i); en_i = 1'b1;
  endtask

  task automatic t_reset;
    int seen;
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      if (!scl_o || rise_o || fall_o || sample_o || change_o) seen++;
    end
    chk("R1 idle scl high, no strobes", seen, 0);
  endtask

  task automatic t_enable;
    set_cfg(8'd1, 16'd5, 16'd7);
    @(negedge clk_i); en_i = 1'b1;
    @(negedge clk_i);
    chk("R2 scl low after enable", int'(scl_o), 0);
    chk("R2 fall strobe on enable", int'(fall_o), 1);
    @(negedge clk_i);
    chk("R8 fall strobe one cycle", int'(fall_o), 0);
  endtask

  task automatic t_timing(input logic [7:0] p, input logic [15:0] l, input logic [15:0] h,
                          input string tag);
    int lo, hi, smp, chg, d, lf, hf;
    d = int'(p) + 1; lf = int'(l[7:0]); hf = int'(h[7:0]);
    restart(p, l, h);
    measure(1'b0, 0, 0, 0, lo, hi, smp, chg);
    chk({"R3 low phase ", tag}, lo, (lf + 7) * d);
    chk({"R4 high phase ", tag}, hi, (hf + 5) * d);
    chk({"R5 period ", tag}, lo + hi, d * (lf + hf + 12));
    chk({"R9 sample point ", tag}, smp, ((hf + 5) / 2) * d);
    chk({"R10 change point ", tag}, chg, ((lf + 7) / 2) * d);
    measure(1'b0, 0, 0, 0, lo, hi, smp, chg);
    chk({"R5 second period ", tag}, lo + hi, d * (lf + hf + 12));
  endtask

  task automatic t_upper;
    int lo, hi, smp, chg;
    restart(8'd1, 16'hA505, 16'h5A07);
    measure(1'b0, 0, 0, 0, lo, hi, smp, chg);
    chk("R6 upper bits ignored low", lo, 24);
    chk("R6 upper bits ignored high", hi, 24);
  endtask

  task automatic t_midchange;
    int lo, hi, smp, chg;
    restart(8'd1, 16'd5, 16'd7);
    measure(1'b1, 8'd0, 16'd0, 16'd0, lo, hi, smp, chg);
    chk("R7 mid-period write keeps low", lo, 24);
    chk("R7 mid-period write keeps high", hi, 24);
    measure(1'b0, 0, 0, 0, lo, hi, smp, chg);
    chk("R7 new low next period", lo, 7);
    chk("R7 new high next period", hi, 5);
  endtask

  task automatic t_coincide;
    int lo, hi, smp, chg;
    restart(8'd0, 16'd0, 16'd0);
    do @(negedge clk_i); while (!rise_o);
    for (int i = 0; i < 4; i++) @(negedge clk_i);
    set_cfg(8'd1, 16'd5, 16'd7);
    measure(1'b0, 0, 0, 0, lo, hi, smp, chg);
    chk("R7 write on period edge low", lo, 24);
    chk("R7 write on period edge high", hi, 24);
  endtask

  task automatic t_disable;
    int seen, lo, hi, smp, chg;
    restart(8'd2, 16'd3, 16'd3);
    do @(negedge clk_i); while (!rise_o);
    @(negedge clk_i); @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    chk("R1 release on disable", int'(scl_o), 1);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      if (!scl_o || rise_o || fall_o || sample_o || change_o) seen++;
      @(negedge clk_i);
    end
    chk("R1 quiet while disabled", seen, 0);
    set_cfg(8'd0, 16'd1, 16'd2);
    en_i = 1'b1;
    @(negedge clk_i);
    chk("R2 fall on re-enable", int'(fall_o), 1);
    while (1) begin
      @(negedge clk_i);
      if (rise_o) break;
      lo++;
    end
    lo = 0; hi = 0; smp = 0; chg = 0;
    measure(1'b0, 0, 0, 0, lo, hi, smp, chg);
    chk("R3 fresh low after re-enable", lo, 8);
    chk("R4 fresh high after re-enable", hi, 7);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_enable();
    t_timing(8'd1, 16'd5,  16'd7,  "psc1 5/7");
    t_timing(8'd0, 16'd0,  16'd0,  "psc0 0/0");
    t_timing(8'd3, 16'd23, 16'd25, "psc3 23/25");
    t_timing(8'd2, 16'd10, 16'd3,  "psc2 10/3");
    t_upper();
    t_midchange();
    t_coincide();
    t_disable();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule